// File: doc/BRIEF.md
# Software Write-Protect Register Unit

This unit holds the protection state for the lower half (addresses 00h to 7Fh) of a 256-byte nonvolatile array behind a two-wire serial slave. It keeps two flags. One is a reversible lock that a clear command can remove. The other is a one-time lock that nothing short of a power-on reset removes. The unit receives already-framed bytes from the bus slave: the slave-address byte, the word-address byte, each data byte and the STOP event. For each byte it returns an ACK or NACK decision. At STOP it tells the write-cycle controller whether a cycle starts and what kind of cycle it is.

Protect commands arrive under the alternate device type code. Their word and data contents carry no meaning. The unit never exposes its flags directly. Software learns the protection state from the pattern of acknowledges it gets back. The hardware write-protect pin is combined with the flags when a memory write is judged. Bus timing, the array itself and the write-cycle timer live in other blocks.

Top module: `protGuard`

## Requirements
- R1: After reset both flags are clear, `ackValid` and `wrStart` are low and `ackGive` is low. With the write-protect pin low, a memory write to any address is acknowledged and starts a cycle.
- R2: The slave byte is read as type in bits 7:4, device field in bits 3:1 and read/write in bit 0 (1 = read). Type 1010 with a device field equal to `devPins` is acknowledged for both reads and writes. Any other device field gets a NACK, and the bytes that follow it also get a NACK.
- R3: With the read/write bit 0, type 0110 selects a protect command. With `a0HighVolt` high, device field 001 means set-reversible and 011 means clear. With `a0HighVolt` low, a device field equal to `devPins` means set-permanent. Every other 0110 byte, including any with the read bit set, gets a NACK.
- R4: For an accepted protect command, the word byte is acknowledged whatever its value. The data byte is acknowledged whatever its value when the write-protect pin is low.
- R5: `ackValid` pulses high for exactly one cycle, in the cycle after each slave, word or data strobe. `ackGive` carries the decision in that cycle.
- R6: While the reversible flag is set, data bytes aimed at 00h–7Fh get a NACK, and no cycle starts unless some data byte was acknowledged. Addresses 80h–FFh are unaffected. Within a page write the address moves only in its low four bits.
- R7: An accepted clear command, once its cycle starts, removes the reversible flag, so that writes to the lower half are acknowledged again.
- R8: Once the permanent flag is set, all three protect commands get a slave-byte NACK, the flag survives any clear attempt, and lower-half data bytes get a NACK whatever the pin state.
- R9: With the write-protect pin high, every data byte gets a NACK. This holds for memory writes at any address and for protect commands, and no cycle then starts.
- R10: With only the reversible flag set, a repeated set-reversible command gets a NACK, while clear and set-permanent are acknowledged.
- R11: `wrStart` pulses one cycle after STOP only when at least one data byte of the current command was acknowledged. `wrKind` then reads 0 for a memory write, 1 for set-reversible, 2 for set-permanent and 3 for clear. A flag change takes effect on the same edge.
- R12: While `cycleBusy` is high, a slave byte gets a NACK and the word and data bytes after it get a NACK too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| devPins | input | 3 | Device address strapped on the address pins |
| a0HighVolt | input | 1 | High-voltage level detected on the lowest address pin |
| wpPin | input | 1 | Hardware write-protect pin, high blocks writes |
| cycleBusy | input | 1 | Internal write cycle in progress |
| slvStrobe | input | 1 | Slave-address byte received |
| slvByte | input | 8 | The received slave-address byte |
| wordStrobe | input | 1 | Word-address byte received |
| wordByte | input | 8 | The received word-address byte |
| dataStrobe | input | 1 | Data byte received |
| stopSeen | input | 1 | STOP condition detected |
| ackValid | output | 1 | Acknowledge decision is valid this cycle |
| ackGive | output | 1 | 1 = drive ACK, 0 = leave NACK |
| wrStart | output | 1 | Start a write cycle |
| wrKind | output | 2 | Cycle kind: 0 memory, 1 set-reversible, 2 set-permanent, 3 clear |

## Verification
The assertions assume that the bus slave raises at most one of the four strobes in any cycle. They also assume that a data byte only ever follows its word byte within a command. The bench drives each strobe as a single-cycle pulse separated by idle cycles and always sends bytes in slave, word, data, STOP order. The pin inputs change only between commands, so every acknowledge it predicts follows from the flag state left by earlier accepted commands.

// File: rtl/protPkg.sv
package protPkg;
  typedef enum logic [2:0] {
    CK_NONE, CK_MEM, CK_READ, CK_SET, CK_PERM, CK_CLR
  } cmdKind_t;

  typedef enum logic [1:0] {
    WK_MEM  = 2'd0,
    WK_SET  = 2'd1,
    WK_PERM = 2'd2,
    WK_CLR  = 2'd3
  } wrKind_t;

  typedef struct packed {
    logic loadAddr;
    logic bumpAddr;
    logic setRev;
    logic clrRev;
    logic setPerm;
  } regStrobe_t;
endpackage

// File: rtl/protRegs.sv
module protRegs
  import protPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [ADDR_W-1:0] wordByte,
  output logic              revFlag,
  output logic              permFlag,
  output logic              lowLocked
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic [ADDR_W-1:0] addrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      revFlag  <= 1'b0;
      permFlag <= 1'b0;
    end else begin
      if (strb.loadAddr)
        addrQ <= wordByte;
      else if (strb.bumpAddr)
        addrQ[PAGE_W-1:0] <= addrQ[PAGE_W-1:0] + 1'b1;
      if (strb.setRev)
        revFlag <= 1'b1;
      else if (strb.clrRev)
        revFlag <= 1'b0;
      if (strb.setPerm)
        permFlag <= 1'b1;
    end
  end

  assign lowLocked = ~addrQ[ADDR_W-1] & (revFlag | permFlag);

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    permFlag |=> permFlag); // R8

  AST_PAGE_HI_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    strb.bumpAddr && !strb.loadAddr |=>
      addrQ[ADDR_W-1 -: HI_W] == $past(addrQ[ADDR_W-1 -: HI_W])); // R6
endmodule

// File: rtl/protCtrl.sv
module protCtrl
  import protPkg::*;
#(
  parameter int               TYPE_W    = 4,
  parameter int               DEV_W     = 3,
  parameter logic [TYPE_W-1:0] TYPE_MEM  = 4'b1010,
  parameter logic [TYPE_W-1:0] TYPE_PROT = 4'b0110,
  parameter logic [DEV_W-1:0]  DEV_SET   = 3'b001,
  parameter logic [DEV_W-1:0]  DEV_CLR   = 3'b011
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [DEV_W-1:0]        devPins,
  input  logic                    a0HighVolt,
  input  logic                    wpPin,
  input  logic                    cycleBusy,
  input  logic                    slvStrobe,
  input  logic [TYPE_W+DEV_W:0]   slvByte,
  input  logic                    wordStrobe,
  input  logic                    dataStrobe,
  input  logic                    stopSeen,
  input  logic                    revFlag,
  input  logic                    permFlag,
  input  logic                    lowLocked,
  output regStrobe_t              strb,
  output logic                    ackValid,
  output logic                    ackGive,
  output logic                    wrStart,
  output logic [1:0]              wrKind
);
  localparam int SLV_W = TYPE_W + DEV_W + 1;

  cmdKind_t          curKind, slvKind;
  logic              gotWord, armed;
  logic [TYPE_W-1:0] typeF;
  logic [DEV_W-1:0]  devF;
  logic              rnwF, slvAck, isWrite, wordAck, dataAck, commit;

  always_comb begin
    typeF   = slvByte[SLV_W-1 -: TYPE_W];
    devF    = slvByte[DEV_W:1];
    rnwF    = slvByte[0];
    slvKind = CK_NONE;
    if (!cycleBusy) begin
      if (typeF == TYPE_MEM && devF == devPins)
        slvKind = rnwF ? CK_READ : CK_MEM;
      else if (typeF == TYPE_PROT && !rnwF) begin
        if (a0HighVolt) begin
          if (devF == DEV_SET)      slvKind = CK_SET;
          else if (devF == DEV_CLR) slvKind = CK_CLR;
        end else if (devF == devPins) begin
          slvKind = CK_PERM;
        end
      end
    end
    case (slvKind)
      CK_MEM, CK_READ: slvAck = 1'b1;
      CK_SET:          slvAck = !permFlag && !revFlag;
      CK_CLR, CK_PERM: slvAck = !permFlag;
      default:         slvAck = 1'b0;
    endcase
  end

  assign isWrite = (curKind == CK_MEM) || (curKind == CK_SET) ||
                   (curKind == CK_PERM) || (curKind == CK_CLR);
  assign wordAck = isWrite && !gotWord;
  assign dataAck = isWrite && gotWord && !wpPin &&
                   !(curKind == CK_MEM && lowLocked);
  assign commit  = stopSeen && armed;

  always_comb begin
    strb.loadAddr = wordStrobe && wordAck && curKind == CK_MEM;
    strb.bumpAddr = dataStrobe && dataAck && curKind == CK_MEM;
    strb.setRev   = commit && curKind == CK_SET;
    strb.setPerm  = commit && curKind == CK_PERM;
    strb.clrRev   = commit && curKind == CK_CLR;
  end

  function automatic logic [1:0] kindCode(cmdKind_t k);
    case (k)
      CK_SET:  return WK_SET;
      CK_PERM: return WK_PERM;
      CK_CLR:  return WK_CLR;
      default: return WK_MEM;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curKind  <= CK_NONE;
      gotWord  <= 1'b0;
      armed    <= 1'b0;
      ackValid <= 1'b0;
      ackGive  <= 1'b0;
      wrStart  <= 1'b0;
      wrKind   <= WK_MEM;
    end else begin
      ackValid <= 1'b0;
      wrStart  <= commit;
      if (commit) wrKind <= kindCode(curKind);
      if (slvStrobe) begin
        curKind  <= slvAck ? slvKind : CK_NONE;
        gotWord  <= 1'b0;
        armed    <= 1'b0;
        ackValid <= 1'b1;
        ackGive  <= slvAck;
      end else if (wordStrobe) begin
        gotWord  <= gotWord | wordAck;
        ackValid <= 1'b1;
        ackGive  <= wordAck;
      end else if (dataStrobe) begin
        armed    <= armed | dataAck;
        ackValid <= 1'b1;
        ackGive  <= dataAck;
      end else if (stopSeen) begin
        curKind <= CK_NONE;
        gotWord <= 1'b0;
        armed   <= 1'b0;
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $countones({slvStrobe, wordStrobe, dataStrobe, stopSeen}) <= 1); // R5
  AST_ACK_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(slvStrobe || wordStrobe || dataStrobe)); // R5
  AST_START_AFTER_STOP: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |-> $past(stopSeen)); // R11
  AST_BUSY_NACK: assert property (@(posedge clk) disable iff (!rstN)
    slvStrobe && cycleBusy |=> ackValid && !ackGive); // R12
  AST_WP_DATA_NACK: assert property (@(posedge clk) disable iff (!rstN)
    dataStrobe && wpPin |=> !ackGive); // R9
  AST_PERM_PROT_NACK: assert property (@(posedge clk) disable iff (!rstN)
    slvStrobe && permFlag && typeF == TYPE_PROT |=> !ackGive); // R8
endmodule

// File: rtl/protGuard.sv
module protGuard
  import protPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PAGE_W = 4,
  parameter int DEV_W  = 3,
  parameter int TYPE_W = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DEV_W-1:0]      devPins,
  input  logic                  a0HighVolt,
  input  logic                  wpPin,
  input  logic                  cycleBusy,
  input  logic                  slvStrobe,
  input  logic [TYPE_W+DEV_W:0] slvByte,
  input  logic                  wordStrobe,
  input  logic [ADDR_W-1:0]     wordByte,
  input  logic                  dataStrobe,
  input  logic                  stopSeen,
  output logic                  ackValid,
  output logic                  ackGive,
  output logic                  wrStart,
  output logic [1:0]            wrKind
);
  regStrobe_t strb;
  logic       revFlag, permFlag, lowLocked;

  protCtrl #(.TYPE_W(TYPE_W), .DEV_W(DEV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .devPins(devPins), .a0HighVolt(a0HighVolt),
    .wpPin(wpPin), .cycleBusy(cycleBusy), .slvStrobe(slvStrobe),
    .slvByte(slvByte), .wordStrobe(wordStrobe), .dataStrobe(dataStrobe),
    .stopSeen(stopSeen), .revFlag(revFlag), .permFlag(permFlag),
    .lowLocked(lowLocked), .strb(strb), .ackValid(ackValid),
    .ackGive(ackGive), .wrStart(wrStart), .wrKind(wrKind)
  );

  protRegs #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .wordByte(wordByte),
    .revFlag(revFlag), .permFlag(permFlag), .lowLocked(lowLocked)
  );
endmodule

// File: tb/sim_protGuard.sv
`timescale 1ns/1ps
module sim_protGuard;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] devPins = 3'b010;
  logic       a0HighVolt = 1'b0, wpPin = 1'b0, cycleBusy = 1'b0;
  logic       slvStrobe = 1'b0, wordStrobe = 1'b0, dataStrobe = 1'b0, stopSeen = 1'b0;
  logic [7:0] slvByte = '0, wordByte = '0;
  logic       ackValid, ackGive, wrStart;
  logic [1:0] wrKind;

  int    nRun = 0, nFail = 0;
  bit    finished = 0;
  bit    expQ[$];
  string tagQ[$];

  localparam logic [7:0] MEM_WR = 8'hA4, MEM_RD = 8'hA5, MEM_OTHER = 8'hA0;
  localparam logic [7:0] P_SET = 8'h62, P_CLR = 8'h66, P_PERM = 8'h64;

  always #5 clk = ~clk;

  protGuard u0 (
    .clk(clk), .rstN(rstN), .devPins(devPins), .a0HighVolt(a0HighVolt),
    .wpPin(wpPin), .cycleBusy(cycleBusy), .slvStrobe(slvStrobe),
    .slvByte(slvByte), .wordStrobe(wordStrobe), .wordByte(wordByte),
    .dataStrobe(dataStrobe), .stopSeen(stopSeen), .ackValid(ackValid),
    .ackGive(ackGive), .wrStart(wrStart), .wrKind(wrKind)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pop expected acknowledge when the design reports one
  always @(negedge clk) begin
    if (rstN && ackValid) begin
      if (expQ.size() == 0) check("R5 unexpected ack", 8'd1, 8'd0);
      else begin
        automatic bit    e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        check(t, {7'd0, ackGive}, {7'd0, e});
      end
    end
  end

  task automatic strobe(input int which, input logic [7:0] val, input bit exp, input string tag);
    @(negedge clk);
    expQ.push_back(exp);
    tagQ.push_back(tag);
    case (which)
      0: begin slvByte = val; slvStrobe = 1'b1; end
      1: begin wordByte = val; wordStrobe = 1'b1; end
      default: dataStrobe = 1'b1;
    endcase
    @(negedge clk);
    slvStrobe = 1'b0; wordStrobe = 1'b0; dataStrobe = 1'b0;
    @(negedge clk);
    check("R5 ack pulse width", {7'd0, ackValid}, 8'd0);
  endtask

  task automatic stop(input bit expStart, input logic [1:0] expKind, input string tag);
    @(negedge clk);
    stopSeen = 1'b1;
    @(negedge clk);
    stopSeen = 1'b0;
    check(tag, {7'd0, wrStart}, {7'd0, expStart});
    if (expStart) check(tag, {6'd0, wrKind}, {6'd0, expKind});
    @(negedge clk);
  endtask

  task automatic memWrite(input logic [7:0] a, input bit expData, input string tag);
    strobe(0, MEM_WR, 1'b1, tag);
    strobe(1, a, 1'b1, tag);
    strobe(2, 8'h5A, expData, tag);
    stop(expData, 2'd0, tag);
  endtask

  task automatic protCmd(input logic [7:0] s, input bit hv, input bit expSlv,
                         input bit expData, input logic [1:0] kind, input string tag);
    a0HighVolt = hv;
    strobe(0, s, expSlv, tag);
    strobe(1, 8'h3C, expSlv, tag);
    strobe(2, 8'hC3, expSlv && expData, tag);
    stop(expSlv && expData, kind, tag);
    a0HighVolt = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset ackValid", {7'd0, ackValid}, 8'd0);
    check("R1 reset wrStart", {7'd0, wrStart}, 8'd0);
    check("R1 reset ackGive", {7'd0, ackGive}, 8'd0);
    rstN = 1'b1;
    memWrite(8'h10, 1'b1, "R1 write low half");
    // no data before stop: no cycle
    strobe(0, MEM_WR, 1'b1, "R11 slave");
    strobe(1, 8'h20, 1'b1, "R11 word");
    stop(1'b0, 2'd0, "R11 no data no start");
    // slave decode
    strobe(0, MEM_OTHER, 1'b0, "R2 device mismatch");
    strobe(1, 8'h00, 1'b0, "R2 word after nack");
    stop(1'b0, 2'd0, "R2 no start");
    strobe(0, MEM_RD, 1'b1, "R2 read ack");
    stop(1'b0, 2'd0, "R2 read no start");
    strobe(0, 8'h63, 1'b0, "R3 protect read bit");
    stop(1'b0, 2'd0, "R3 read bit no start");
    protCmd(P_SET, 1'b0, 1'b0, 1'b1, 2'd1, "R3 set without high volt");
    protCmd(P_SET, 1'b1, 1'b1, 1'b1, 2'd1, "R4 set reversible");
    memWrite(8'h05, 1'b0, "R6 low half locked");
    memWrite(8'h85, 1'b1, "R6 upper half open");
    // page write wrapping inside the low half stays locked
    strobe(0, MEM_WR, 1'b1, "R6 page slave");
    strobe(1, 8'h7F, 1'b1, "R6 page word");
    strobe(2, 8'h00, 1'b0, "R6 page byte0");
    strobe(2, 8'h00, 1'b0, "R6 page byte1");
    stop(1'b0, 2'd0, "R6 page no start");
    protCmd(P_SET, 1'b1, 1'b0, 1'b1, 2'd1, "R10 repeated set nack");
    cycleBusy = 1'b1;
    strobe(0, MEM_WR, 1'b0, "R12 busy slave");
    strobe(1, 8'h90, 1'b0, "R12 busy word");
    strobe(2, 8'h00, 1'b0, "R12 busy data");
    stop(1'b0, 2'd0, "R12 busy no start");
    cycleBusy = 1'b0;
    protCmd(P_CLR, 1'b1, 1'b1, 1'b1, 2'd3, "R10 clear acked");
    memWrite(8'h05, 1'b1, "R7 lower half reopened");
    wpPin = 1'b1;
    memWrite(8'h85, 1'b0, "R9 pin blocks upper");
    protCmd(P_SET, 1'b1, 1'b1, 1'b0, 2'd1, "R9 protect with pin high");
    wpPin = 1'b0;
    memWrite(8'h06, 1'b1, "R9 set was not applied");
    protCmd(P_SET, 1'b1, 1'b1, 1'b1, 2'd1, "R4 set again");
    protCmd(P_PERM, 1'b0, 1'b1, 1'b1, 2'd2, "R10 permanent acked");
    protCmd(P_SET, 1'b1, 1'b0, 1'b1, 2'd1, "R8 set nack");
    protCmd(P_CLR, 1'b1, 1'b0, 1'b1, 2'd3, "R8 clear nack");
    protCmd(P_PERM, 1'b0, 1'b0, 1'b1, 2'd2, "R8 permanent nack");
    memWrite(8'h20, 1'b0, "R8 low half still locked");
    memWrite(8'hA0, 1'b1, "R8 upper half open");
    if (expQ.size() != 0) check("R5 missing acks", 8'(expQ.size()), 8'd0);
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule